// File: doc/BRIEF.md
# Multi-Level Bus Arbiter with Local Requester

This block decides which of four request levels may take a shared parallel bus next, and it also holds the request logic for the local master that sits on the same bus. Request levels are numbered 0 to 3. The arbiter offers one grant at a time, and only while nobody holds the bus. It can pick the winner in one of two ways. In fixed-priority mode the highest-numbered level always wins. In rotating mode the search starts just below the level that won last time. In fixed-priority mode it also raises a bus-clear signal when a request above the current owner's level turns up while the bus is busy. This asks the owner to let go.

The local requester watches a "need" input from the local master. It places a request on a chosen level and takes the bus when the grant for that level comes back. It then drives its own busy signal. Two settings shape its manners. The first chooses whether it defers to a pending request on its own level (fair) or requests at once (demand). The second chooses whether it lets go as soon as the master is finished, or keeps the bus until another master asks for it. Inside the block, the local request and busy are merged with the external request and busy lines before they reach the arbiter.

Top module: `busarb_unit`

## Requirements
- R1: After reset, all grants, bus-clear, the local request and the local busy are low.
- R2: In fixed-priority mode (`cfg_rotate`=0), when the bus is idle and requests are pending, the clock edge that sees them sets exactly one grant bit: the one for the highest-numbered pending level (bit n of `grant_o` is level n).
- R3: In rotating mode (`cfg_rotate`=1), the search for the winner begins one level below the last level granted and wraps from level 0 to level 3. After reset the first search begins at level 3.
- R4: At most one grant bit is high at any time. No grant is issued on an edge that sees the merged busy high. An offered grant drops on the edge that first sees busy high.
- R5: An offered grant is withdrawn on the edge that sees its level's request low while busy is still low.
- R6: In fixed-priority mode, bus-clear rises one edge after a request above the owner's level is seen while busy is held. It stays low for requests at or below the owner's level, and it stays low in rotating mode.
- R7: Bus-clear falls on the edge that sees busy released. The next grant can appear no earlier than the edge after that.
- R8: In demand mode (`cfg_fair`=0), the local request goes high on bit `loc_level` at the edge after `loc_need` is seen, even if another master is requesting on the same level.
- R9: In fair mode (`cfg_fair`=1), the local request stays low while `bus_req_i[loc_level]` is high, and it rises at the first edge that sees that line low.
- R10: On the edge where the requester sees its level's grant, `loc_busy_o` rises and `loc_req_o` clears. The two are never high together.
- R11: With `cfg_hold`=0 (release when done), `loc_busy_o` falls at the edge after `loc_need` is seen low.
- R12: With `cfg_hold`=1 (release on request), `loc_busy_o` stays high with `loc_need` low until some bit of `bus_req_i` is seen high, and falls at that edge.
- R13: If `loc_need` drops before a grant arrives, the local request clears at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rotate | input | 1 | 1 = rotating selection, 0 = fixed priority |
| cfg_fair | input | 1 | 1 = fair requesting, 0 = demand requesting |
| cfg_hold | input | 1 | 1 = release on request, 0 = release when done |
| bus_req_i | input | 4 | Request lines from other masters, bit n = level n |
| bus_busy_i | input | 1 | Busy driven by another master |
| grant_o | output | 4 | Grant per level, one-hot or zero |
| bus_clear_o | output | 1 | Request for the current owner to release |
| loc_need | input | 1 | The local master wants the bus |
| loc_level | input | 2 | Level on which the local master requests |
| loc_req_o | output | 4 | Local request, one-hot on its level |
| loc_busy_o | output | 1 | Local master holds the bus |

## Verification
The sharpest overlap comes when the local master holds the bus in release-on-request mode with its need gone, and another master raises a request above the local level. On that one edge the arbiter's bus-clear and the requester's release both fire. The bench sets up exactly that state and checks three things on consecutive edges: `loc_busy_o` falling in the same cycle that `bus_clear_o` rises, bus-clear falling on the next edge, and the grant to the newcomer only on the edge after that. A second overlap, where a grant is offered and a withdrawn request or a fresh busy arrive together, is covered by the withdraw and busy-hold scenarios.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_OFFER = 2'd1,
    ARB_HELD  = 2'd2
  } arb_state_e;

  typedef enum logic [1:0] {
    RQ_IDLE = 2'd0,
    RQ_WAIT = 2'd1,
    RQ_OWN  = 2'd2
  } rq_state_e;

endpackage

// File: rtl/busarb_pick.sv
module busarb_pick #(
  parameter int NLVL = 4,
  localparam int LW = $clog2(NLVL)
) (
  input  logic [NLVL-1:0] req_i,
  input  logic            rotate_i,
  input  logic [LW-1:0]   last_i,
  output logic            hit_o,
  output logic [LW-1:0]   lvl_o
);

  // candidate level examined at search offset g (offset 0 examined first)
  logic [LW-1:0] cand [NLVL];

  for (genvar g = 0; g < NLVL; g++) begin : g_cand
    assign cand[g] = rotate_i
      ? LW'((int'(last_i) + 2*NLVL - 1 - g) % NLVL)
      : LW'(NLVL - 1 - g);
  end

  always_comb begin
    hit_o = 1'b0;
    lvl_o = '0;
    for (int i = NLVL - 1; i >= 0; i--) begin
      if (req_i[cand[i]]) begin
        hit_o = 1'b1;
        lvl_o = cand[i];
      end
    end
  end

endmodule

// File: rtl/busarb_arbiter.sv
module busarb_arbiter
  import busarb_pkg::*;
#(
  parameter int NLVL = 4,
  localparam int LW = $clog2(NLVL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rotate_i,
  input  logic [NLVL-1:0] req_i,
  input  logic            busy_i,
  output logic [NLVL-1:0] grant_o,
  output logic            clear_o
);

  arb_state_e      st_q, st_d;
  logic [NLVL-1:0] grant_q, grant_d;
  logic [LW-1:0]   owner_q, owner_d;
  logic [LW-1:0]   last_q, last_d;
  logic            clear_q, clear_d;
  logic            pick_hit;
  logic [LW-1:0]   pick_lvl;
  logic [NLVL-1:0] above;

  busarb_pick #(.NLVL(NLVL)) u_pick (
    .req_i    (req_i),
    .rotate_i (rotate_i),
    .last_i   (last_q),
    .hit_o    (pick_hit),
    .lvl_o    (pick_lvl)
  );

  for (genvar g = 0; g < NLVL; g++) begin : g_above
    assign above[g] = (LW'(g) > owner_q);
  end

  always_comb begin
    st_d    = st_q;
    grant_d = grant_q;
    owner_d = owner_q;
    last_d  = last_q;
    clear_d = clear_q;
    unique case (st_q)
      ARB_IDLE: begin
        clear_d = 1'b0;
        if (!busy_i && pick_hit) begin
          grant_d           = '0;
          grant_d[pick_lvl] = 1'b1;
          owner_d           = pick_lvl;
          last_d            = pick_lvl;
          st_d              = ARB_OFFER;
        end
      end
      ARB_OFFER: begin
        clear_d = 1'b0;
        if (busy_i) begin
          grant_d = '0;
          st_d    = ARB_HELD;
        end else if (!req_i[owner_q]) begin
          grant_d = '0;
          st_d    = ARB_IDLE;
        end
      end
      ARB_HELD: begin
        if (!busy_i) begin
          clear_d = 1'b0;
          st_d    = ARB_IDLE;
        end else begin
          clear_d = !rotate_i && (|(req_i & above));
        end
      end
      default: begin
        grant_d = '0;
        clear_d = 1'b0;
        st_d    = ARB_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ARB_IDLE;
      grant_q <= '0;
      owner_q <= '0;
      last_q  <= '0;
      clear_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      grant_q <= grant_d;
      owner_q <= owner_d;
      last_q  <= last_d;
      clear_q <= clear_d;
    end
  end

  assign grant_o = grant_q;
  assign clear_o = clear_q;

  assert_onehot_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  assert_grant_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|grant_o) |-> !$past(busy_i));

  assert_clear_rotate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rotate_i) |-> !clear_o);

  assert_clear_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |=> !clear_o);

endmodule

// File: rtl/busarb_requester.sv
module busarb_requester
  import busarb_pkg::*;
#(
  parameter int NLVL = 4,
  localparam int LW = $clog2(NLVL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            need_i,
  input  logic [LW-1:0]   lvl_i,
  input  logic            fair_i,
  input  logic            hold_i,
  input  logic [NLVL-1:0] other_req_i,
  input  logic [NLVL-1:0] grant_i,
  output logic [NLVL-1:0] req_o,
  output logic            busy_o
);

  rq_state_e       st_q, st_d;
  logic [LW-1:0]   lvl_q, lvl_d;
  logic [NLVL-1:0] req_q, req_d;
  logic            busy_q, busy_d;
  logic            may_ask, may_leave;

  assign may_ask   = need_i && !(fair_i && other_req_i[lvl_i]);
  assign may_leave = !need_i && (!hold_i || (|other_req_i));

  always_comb begin
    st_d   = st_q;
    lvl_d  = lvl_q;
    req_d  = req_q;
    busy_d = busy_q;
    unique case (st_q)
      RQ_IDLE: begin
        if (may_ask) begin
          st_d         = RQ_WAIT;
          lvl_d        = lvl_i;
          req_d        = '0;
          req_d[lvl_i] = 1'b1;
        end
      end
      RQ_WAIT: begin
        if (!need_i) begin
          st_d  = RQ_IDLE;
          req_d = '0;
        end else if (grant_i[lvl_q]) begin
          st_d   = RQ_OWN;
          req_d  = '0;
          busy_d = 1'b1;
        end
      end
      RQ_OWN: begin
        if (may_leave) begin
          st_d   = RQ_IDLE;
          busy_d = 1'b0;
        end
      end
      default: begin
        st_d   = RQ_IDLE;
        req_d  = '0;
        busy_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RQ_IDLE;
      lvl_q  <= '0;
      req_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      lvl_q  <= lvl_d;
      req_q  <= req_d;
      busy_q <= busy_d;
    end
  end

  assign req_o  = req_q;
  assign busy_o = busy_q;

  assert_req_busy_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !((|req_o) && busy_o));

  assert_fair_holdoff_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RQ_IDLE && fair_i && other_req_i[lvl_i]) |=> (req_o == '0));

  assert_release_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !need_i && !hold_i) |=> !busy_o);

endmodule

// File: rtl/busarb_unit.sv
module busarb_unit #(
  parameter int NLVL = 4,
  localparam int LW = $clog2(NLVL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_rotate,
  input  logic            cfg_fair,
  input  logic            cfg_hold,
  input  logic [NLVL-1:0] bus_req_i,
  input  logic            bus_busy_i,
  output logic [NLVL-1:0] grant_o,
  output logic            bus_clear_o,
  input  logic            loc_need,
  input  logic [LW-1:0]   loc_level,
  output logic [NLVL-1:0] loc_req_o,
  output logic            loc_busy_o
);

  logic [NLVL-1:0] merged_req;
  logic            merged_busy;

  assign merged_req  = bus_req_i | loc_req_o;
  assign merged_busy = bus_busy_i | loc_busy_o;

  busarb_arbiter #(.NLVL(NLVL)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .rotate_i (cfg_rotate),
    .req_i    (merged_req),
    .busy_i   (merged_busy),
    .grant_o  (grant_o),
    .clear_o  (bus_clear_o)
  );

  busarb_requester #(.NLVL(NLVL)) u_req (
    .clk         (clk),
    .rst_n       (rst_n),
    .need_i      (loc_need),
    .lvl_i       (loc_level),
    .fair_i      (cfg_fair),
    .hold_i      (cfg_hold),
    .other_req_i (bus_req_i),
    .grant_i     (grant_o),
    .req_o       (loc_req_o),
    .busy_o      (loc_busy_o)
  );

endmodule

// File: tb/busarb_unit_test.sv
module busarb_unit_test;

  logic       clk;
  logic       rst_n;
  logic       cfg_rotate, cfg_fair, cfg_hold;
  logic [3:0] bus_req_i;
  logic       bus_busy_i;
  logic [3:0] grant_o;
  logic       bus_clear_o;
  logic       loc_need;
  logic [1:0] loc_level;
  logic [3:0] loc_req_o;
  logic       loc_busy_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  busarb_unit #(.NLVL(4)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_rotate  (cfg_rotate),
    .cfg_fair    (cfg_fair),
    .cfg_hold    (cfg_hold),
    .bus_req_i   (bus_req_i),
    .bus_busy_i  (bus_busy_i),
    .grant_o     (grant_o),
    .bus_clear_o (bus_clear_o),
    .loc_need    (loc_need),
    .loc_level   (loc_level),
    .loc_req_o   (loc_req_o),
    .loc_busy_o  (loc_busy_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n      = 1'b0;
    cfg_rotate = 1'b0;
    cfg_fair   = 1'b0;
    cfg_hold   = 1'b0;
    bus_req_i  = '0;
    bus_busy_i = 1'b0;
    loc_need   = 1'b0;
    loc_level  = '0;
    step();
    step();
    rst_n = 1'b1;
    step();
  endtask

  // one full offer / take / hold / release round
  task automatic grant_round(input logic [3:0] req, input int lvl, input logic exp_clr,
                             input string tag);
    bus_req_i  = req;
    bus_busy_i = 1'b0;
    step();
    check({tag, " grant"}, 32'(grant_o), 32'(4'b0001 << lvl));
    bus_busy_i = 1'b1;
    step();
    check("R4 grant drops on busy", 32'(grant_o), 32'h0);
    step();
    check({tag, " clear while held"}, 32'(bus_clear_o), 32'(exp_clr));
    bus_busy_i = 1'b0;
    bus_req_i  = '0;
    step();
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 grant", 32'(grant_o), 32'h0);
    check("R1 clear", 32'(bus_clear_o), 32'h0);
    check("R1 loc_req", 32'(loc_req_o), 32'h0);
    check("R1 loc_busy", 32'(loc_busy_o), 32'h0);
  endtask

  task automatic t_priority();
    do_reset();
    bus_req_i = 4'b0110;
    step();
    check("R2 highest pending wins", 32'(grant_o), 32'h4);
    bus_busy_i = 1'b1;
    bus_req_i  = 4'b0010;
    step();
    check("R4 grant drops on busy", 32'(grant_o), 32'h0);
    bus_req_i = 4'b1010;
    step();
    check("R6 clear on higher request", 32'(bus_clear_o), 32'h1);
    bus_busy_i = 1'b0;
    step();
    check("R7 clear falls on release", 32'(bus_clear_o), 32'h0);
    check("R7 no grant same edge", 32'(grant_o), 32'h0);
    step();
    check("R7 grant after release", 32'(grant_o), 32'h8);
    bus_busy_i = 1'b1;
    bus_req_i  = '0;
    step();
    bus_req_i = 4'b0100;
    step();
    step();
    check("R6 no clear for lower level", 32'(bus_clear_o), 32'h0);
    bus_busy_i = 1'b0;
    bus_req_i  = '0;
    step();
    grant_round(4'b1111, 3, 1'b0, "R2 all pending");
    grant_round(4'b1111, 3, 1'b0, "R2 all pending again");
  endtask

  task automatic t_rotate();
    do_reset();
    cfg_rotate = 1'b1;
    grant_round(4'b1111, 3, 1'b0, "R3 first search at 3");
    grant_round(4'b1111, 2, 1'b0, "R3 rotate to 2");
    grant_round(4'b1111, 1, 1'b0, "R3 rotate to 1");
    grant_round(4'b1111, 0, 1'b0, "R6 rotate to 0 no clear");
    grant_round(4'b1111, 3, 1'b0, "R3 wrap to 3");
    grant_round(4'b0101, 2, 1'b0, "R3 sparse 2");
    grant_round(4'b0101, 0, 1'b0, "R3 sparse 0");
    grant_round(4'b0101, 2, 1'b0, "R3 sparse wrap 2");
  endtask

  task automatic t_busy_and_withdraw();
    do_reset();
    bus_busy_i = 1'b1;
    bus_req_i  = 4'b1000;
    step();
    check("R4 no grant while busy", 32'(grant_o), 32'h0);
    step();
    check("R4 still no grant while busy", 32'(grant_o), 32'h0);
    bus_busy_i = 1'b0;
    bus_req_i  = 4'b0100;
    step();
    check("R2 grant once idle", 32'(grant_o), 32'h4);
    bus_req_i = '0;
    step();
    check("R5 grant withdrawn", 32'(grant_o), 32'h0);
    bus_req_i = 4'b0001;
    step();
    check("R5 fresh grant after withdraw", 32'(grant_o), 32'h1);
  endtask

  task automatic take_local(input string tag);
    loc_need = 1'b1;
    step();
    check({tag, " request on level"}, 32'(loc_req_o), 32'(4'b0001 << loc_level));
    step();
    check({tag, " grant to local level"}, 32'(grant_o), 32'(4'b0001 << loc_level));
    step();
    check("R10 busy rises", 32'(loc_busy_o), 32'h1);
    check("R10 request cleared", 32'(loc_req_o), 32'h0);
    step();
    check("R4 grant dropped after take", 32'(grant_o), 32'h0);
  endtask

  task automatic t_release_done();
    do_reset();
    loc_level = 2'd1;
    take_local("R8");
    loc_need = 1'b0;
    step();
    check("R11 release when done", 32'(loc_busy_o), 32'h0);
  endtask

  task automatic t_hold_and_clear();
    do_reset();
    cfg_hold  = 1'b1;
    loc_level = 2'd1;
    take_local("R8 hold mode");
    loc_need = 1'b0;
    step();
    step();
    check("R12 keeps bus without request", 32'(loc_busy_o), 32'h1);
    check("R6 no clear without request", 32'(bus_clear_o), 32'h0);
    bus_req_i = 4'b0100;
    step();
    check("R12 release on request", 32'(loc_busy_o), 32'h0);
    check("R6 clear same edge as release", 32'(bus_clear_o), 32'h1);
    step();
    check("R7 clear falls", 32'(bus_clear_o), 32'h0);
    check("R7 grant not yet", 32'(grant_o), 32'h0);
    step();
    check("R7 grant to newcomer", 32'(grant_o), 32'h4);
  endtask

  task automatic t_fair_demand();
    do_reset();
    cfg_fair  = 1'b1;
    loc_level = 2'd1;
    bus_req_i = 4'b0010;
    loc_need  = 1'b1;
    step();
    check("R9 fair holds off", 32'(loc_req_o), 32'h0);
    step();
    check("R9 fair still holds off", 32'(loc_req_o), 32'h0);
    bus_req_i = 4'b0000;
    step();
    check("R9 fair requests when line free", 32'(loc_req_o), 32'h2);
    do_reset();
    loc_level = 2'd1;
    bus_req_i = 4'b0010;
    loc_need  = 1'b1;
    step();
    check("R8 demand requests despite other", 32'(loc_req_o), 32'h2);
  endtask

  task automatic t_need_drop();
    do_reset();
    bus_busy_i = 1'b1;
    loc_level  = 2'd2;
    loc_need   = 1'b1;
    step();
    check("R8 request on level 2", 32'(loc_req_o), 32'h4);
    loc_need = 1'b0;
    step();
    check("R13 request withdrawn", 32'(loc_req_o), 32'h0);
    check("R13 not busy", 32'(loc_busy_o), 32'h0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    t_reset();
    t_priority();
    t_rotate();
    t_busy_and_withdraw();
    t_release_done();
    t_hold_and_clear();
    t_fair_demand();
    t_need_drop();
    done = 1'b1;
    finish_run();
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

endmodule